// File: doc/BRIEF.md
# Addressable Shared-Bus Serial Register Slave

This block is the serial control port of a configurable device. A host reaches its register file through three wires: an active-low frame enable, a serial clock and a data line. Up to four such devices may hang on one bus with no per-device select. Two strap inputs give each device a 2-bit identity. After reset the identity is disregarded and every device takes every write, so the host can configure all of them at once. Once the host sets the addressing bit in the control register, a device acts only on frames whose device field equals its straps.

A frame has 26 bits, sent most significant bit first and sampled on rising serial-clock edges. It carries a direction bit, the 2-bit device field, a 7-bit register index and 16 data bits. For a read, the device supplies the data bits itself once the 10 header bits are in. In three-wire mode it drives them on the shared data line. When the four-wire bit is set it drives them on a dedicated output instead and never drives the data line. The serial pins are brought into the system clock domain through synchronizers. The bus has no back-pressure: the host paces the frame and the slave keeps up as long as each serial half-period lasts several system clocks.

The control register also holds a software-override bit. When it is set, the device enable and mode outputs come from register bits instead of from the pins.

Top module: `serial_ctl_slave`

## Requirements
- R1: After reset all registers read 0, both data-output enables are low, and core_enable/core_mode follow pin_enable/pin_mode.
- R2: Register 0 is the control word: bit 0 turns on addressing, bit 1 selects four-wire readback, bit 2 turns on the software override, bit 3 is the software enable and bit 4 is the software mode. While bit 0 is 0, a write is accepted whatever its device field.
- R3: While bit 0 of register 0 is 1, a frame is acted on only if its device field (frame bits 24:23) equals addr_strap. Other writes leave the registers unchanged.
- R4: A frame is, in transmit order: bit 25 direction (1 = read), bits 24:23 device, bits 22:16 register, bits 15:0 data. A write takes effect only when ser_en_n rises, and only if exactly 26 rising serial-clock edges were seen. Shorter or longer frames change nothing.
- R5: A selected read returns the addressed register MSB first. Bit 15 is valid before the 11th rising serial-clock edge, and the next bit appears after each later rising edge.
- R6: In three-wire mode, dio_oe rises only after the 10th header bit of a selected read and falls once ser_en_n is high. Write frames never drive any output.
- R7: In four-wire mode, read data appears on sdo_out with sdo_oe high, and dio_oe stays low.
- R8: A device that is not selected keeps dio_oe and sdo_oe low for the whole frame.
- R9: While control bit 2 is 1, core_enable and core_mode equal control bits 3 and 4. Otherwise they equal pin_enable and pin_mode.
- R10: Writes to register indices at or above NUM_REGS (default 8) are dropped, and reads of them return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_en_n | input | 1 | Frame enable, low during a frame |
| ser_clk | input | 1 | Serial clock, bits sampled on rising edge |
| ser_din | input | 1 | Serial data in |
| addr_strap | input | 2 | Device identity straps |
| pin_enable | input | 1 | Enable from pin |
| pin_mode | input | 1 | Mode from pin |
| dio_out | output | 1 | Read data for shared line (three-wire) |
| dio_oe | output | 1 | Drive enable of shared line |
| sdo_out | output | 1 | Read data on dedicated pin (four-wire) |
| sdo_oe | output | 1 | Drive enable of dedicated pin |
| core_enable | output | 1 | Enable to the device core |
| core_mode | output | 1 | Mode to the device core |

## Verification
A serial edge reaches the logic through two synchronizer stages and one edge-detect flop, and the read shifter loads one clock after the header completes. A read bit therefore changes about four system clocks after the rising serial edge that causes it. The bench holds every serial half-period for six system clocks and samples the read bit and the enables on the falling clock just before the next rising serial edge. A write commits about four clocks after ser_en_n rises, so the bench waits several half-periods after each frame before it reads back or checks the core outputs.

// File: rtl/serial_ctl_pkg.sv
package serial_ctl_pkg;
  localparam int CTL_ADDR_EN  = 0;
  localparam int CTL_FOUR_W   = 1;
  localparam int CTL_SW_OVR   = 2;
  localparam int CTL_SW_EN    = 3;
  localparam int CTL_SW_MODE  = 4;

  typedef struct packed {
    logic addr_en;
    logic four_wire;
    logic sw_ovr;
    logic sw_en;
    logic sw_mode;
  } ctl_t;
endpackage

// File: rtl/serial_ctl_sync.sv
module serial_ctl_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st[g] <= RST_VAL;
        else if (g == 0) st[g] <= d;
        else st[g] <= st[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign q = st[STAGES-1];
endmodule

// File: rtl/serial_ctl_regs.sv
module serial_ctl_regs
  import serial_ctl_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int REG_AW = 7,
  parameter int NUM_REGS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [REG_AW-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output ctl_t              ctl
);
  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  logic [DATA_W-1:0] mem [NUM_REGS];

  genvar g;
  generate
    for (g = 0; g < NUM_REGS; g++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mem[g] <= '0;
        else if (wr_en && (wr_addr == REG_AW'(g))) mem[g] <= wr_data;
      end
    end
  endgenerate

  always_comb begin
    if (rd_addr < REG_AW'(NUM_REGS)) rd_data = mem[rd_addr[IDX_W-1:0]];
    else rd_data = '0;
  end

  assign ctl.addr_en   = mem[0][CTL_ADDR_EN];
  assign ctl.four_wire = mem[0][CTL_FOUR_W];
  assign ctl.sw_ovr    = mem[0][CTL_SW_OVR];
  assign ctl.sw_en     = mem[0][CTL_SW_EN];
  assign ctl.sw_mode   = mem[0][CTL_SW_MODE];
endmodule

// File: rtl/serial_ctl_frame.sv
module serial_ctl_frame #(
  parameter int DATA_W = 16,
  parameter int REG_AW = 7,
  parameter int DEV_AW = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_s,
  input  logic              en_rise,
  input  logic              sclk_rise,
  input  logic              sdi,
  input  logic              addr_en,
  input  logic              four_wire,
  input  logic [DEV_AW-1:0] addr_strap,
  input  logic [DATA_W-1:0] rd_data,
  output logic [REG_AW-1:0] reg_idx,
  output logic              wr_en,
  output logic [DATA_W-1:0] wr_data,
  output logic [DEV_AW-1:0] hdr_dev,
  output logic              rd_bit,
  output logic              dio_oe,
  output logic              sdo_oe
);
  localparam int HDR_BITS   = 1 + DEV_AW + REG_AW;
  localparam int FRAME_BITS = HDR_BITS + DATA_W;
  localparam int CW         = $clog2(FRAME_BITS + 2);

  logic [DATA_W-1:0]   sh;
  logic [CW-1:0]       cnt;
  logic                hdr_rw;
  logic [HDR_BITS-1:0] hdr_next;
  logic                load_pend;
  logic [DATA_W-1:0]   rd_sh;
  logic                selected;

  assign hdr_next = {sh[HDR_BITS-2:0], sdi};
  assign selected = !addr_en || (hdr_dev == addr_strap);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh <= '0; cnt <= '0; hdr_rw <= 1'b0; hdr_dev <= '0; reg_idx <= '0;
      load_pend <= 1'b0; rd_sh <= '0; dio_oe <= 1'b0; sdo_oe <= 1'b0;
    end else if (en_s) begin
      cnt <= '0;
      load_pend <= 1'b0;
      dio_oe <= 1'b0;
      sdo_oe <= 1'b0;
    end else begin
      load_pend <= 1'b0;
      if (sclk_rise) begin
        sh <= {sh[DATA_W-2:0], sdi};
        if (cnt != CW'(FRAME_BITS + 1)) cnt <= cnt + 1'b1;
        if (cnt == CW'(HDR_BITS - 1)) begin
          hdr_rw    <= hdr_next[HDR_BITS-1];
          hdr_dev   <= hdr_next[HDR_BITS-2 -: DEV_AW];
          reg_idx   <= hdr_next[REG_AW-1:0];
          load_pend <= 1'b1;
        end else if (cnt >= CW'(HDR_BITS)) begin
          rd_sh <= {rd_sh[DATA_W-2:0], 1'b0};
        end
      end
      if (load_pend) begin
        rd_sh  <= rd_data;
        dio_oe <= hdr_rw && selected && !four_wire;
        sdo_oe <= hdr_rw && selected && four_wire;
      end
    end
  end

  assign rd_bit  = rd_sh[DATA_W-1];
  assign wr_en   = en_rise && (cnt == CW'(FRAME_BITS)) && !hdr_rw && selected;
  assign wr_data = sh;
endmodule

// File: rtl/serial_ctl_slave.sv
module serial_ctl_slave
  import serial_ctl_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int REG_AW = 7,
  parameter int DEV_AW = 2,
  parameter int NUM_REGS = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_en_n,
  input  logic              ser_clk,
  input  logic              ser_din,
  input  logic [DEV_AW-1:0] addr_strap,
  input  logic              pin_enable,
  input  logic              pin_mode,
  output logic              dio_out,
  output logic              dio_oe,
  output logic              sdo_out,
  output logic              sdo_oe,
  output logic              core_enable,
  output logic              core_mode
);
  logic [2:0]        raw_s;
  logic              en_s, sclk_s, sdi_s;
  logic              en_prev, sclk_prev, en_rise, sclk_rise;
  logic [REG_AW-1:0] reg_idx;
  logic              wr_en;
  logic [DATA_W-1:0] wr_data, rd_data;
  logic [DEV_AW-1:0] hdr_dev;
  logic              rd_bit;
  ctl_t              ctl;

  serial_ctl_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({ser_en_n, ser_clk, ser_din}), .q(raw_s));

  assign {en_s, sclk_s, sdi_s} = raw_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_prev   <= 1'b1;
      sclk_prev <= 1'b0;
    end else begin
      en_prev   <= en_s;
      sclk_prev <= sclk_s;
    end
  end

  assign en_rise   = en_s && !en_prev;
  assign sclk_rise = sclk_s && !sclk_prev && !en_s;

  serial_ctl_frame #(.DATA_W(DATA_W), .REG_AW(REG_AW), .DEV_AW(DEV_AW)) u_frame (
    .clk(clk), .rst_n(rst_n), .en_s(en_s), .en_rise(en_rise),
    .sclk_rise(sclk_rise), .sdi(sdi_s), .addr_en(ctl.addr_en),
    .four_wire(ctl.four_wire), .addr_strap(addr_strap), .rd_data(rd_data),
    .reg_idx(reg_idx), .wr_en(wr_en), .wr_data(wr_data), .hdr_dev(hdr_dev),
    .rd_bit(rd_bit), .dio_oe(dio_oe), .sdo_oe(sdo_oe));

  serial_ctl_regs #(.DATA_W(DATA_W), .REG_AW(REG_AW), .NUM_REGS(NUM_REGS)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(reg_idx),
    .wr_data(wr_data), .rd_addr(reg_idx), .rd_data(rd_data), .ctl(ctl));

  assign dio_out     = rd_bit;
  assign sdo_out     = rd_bit;
  assign core_enable = ctl.sw_ovr ? ctl.sw_en   : pin_enable;
  assign core_mode   = ctl.sw_ovr ? ctl.sw_mode : pin_mode;
endmodule

// File: rtl/serial_ctl_checker.sv
module serial_ctl_checker #(
  parameter int DEV_AW = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en_s,
  input logic              en_rise,
  input logic              dio_oe,
  input logic              sdo_oe,
  input logic              addr_en,
  input logic              four_wire,
  input logic [DEV_AW-1:0] hdr_dev,
  input logic [DEV_AW-1:0] addr_strap
);
  // R6: outputs released once the frame enable is seen high
  p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    en_s |=> (!dio_oe && !sdo_oe));

  // R7: four-wire mode never drives the shared line
  p_four_wire_r7: assert property (@(posedge clk) disable iff (!rst_n)
    four_wire |-> !dio_oe);

  // R7: three-wire mode never drives the dedicated pin
  p_three_wire_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !four_wire |-> !sdo_oe);

  // R8: a drive enable implies this device is selected
  p_selected_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dio_oe || sdo_oe) |-> (!addr_en || (hdr_dev == addr_strap)));

  // R4: control state changes only right after the frame closes
  p_commit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({addr_en, four_wire}) |-> $past(en_rise));

  // R6: never both enables at once
  p_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(dio_oe && sdo_oe));
endmodule

bind serial_ctl_slave serial_ctl_checker #(.DEV_AW(DEV_AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .en_s(en_s), .en_rise(en_rise),
  .dio_oe(dio_oe), .sdo_oe(sdo_oe), .addr_en(ctl.addr_en),
  .four_wire(ctl.four_wire), .hdr_dev(hdr_dev), .addr_strap(addr_strap));

// File: tb/serial_ctl_slave_tb.sv
module serial_ctl_slave_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_en_n = 1'b1, ser_clk = 1'b0, ser_din = 1'b0;
  logic [1:0] addr_strap = 2'b10;
  logic pin_enable = 1'b0, pin_mode = 1'b0;
  logic dio_out, dio_oe, sdo_out, sdo_oe, core_enable, core_mode;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [15:0] expv [8];

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_ctl_slave dut_i (
    .clk(clk), .rst_n(rst_n), .ser_en_n(ser_en_n), .ser_clk(ser_clk),
    .ser_din(ser_din), .addr_strap(addr_strap), .pin_enable(pin_enable),
    .pin_mode(pin_mode), .dio_out(dio_out), .dio_oe(dio_oe),
    .sdo_out(sdo_out), .sdo_oe(sdo_oe), .core_enable(core_enable),
    .core_mode(core_mode));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit m_sel(input logic [1:0] dev);
    return !expv[0][0] || (dev == addr_strap);
  endfunction

  function automatic logic [15:0] m_read(input logic [6:0] ra);
    return (ra < 7'd8) ? expv[ra[2:0]] : 16'h0;
  endfunction

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic frame(input bit rw, input logic [1:0] dev, input logic [6:0] ra,
                       input logic [15:0] wd, input int nbits, output logic [15:0] rd,
                       output int n_early, output int n_dio, output int n_sdo);
    logic [25:0] f;
    f = {rw, dev, ra, wd};
    rd = '0; n_early = 0; n_dio = 0; n_sdo = 0;
    ser_en_n = 1'b0;
    wclk(HALF);
    for (int i = 0; i < nbits; i++) begin
      ser_din = (i < 26) ? f[25-i] : 1'b0;
      wclk(HALF);
      if (i < 10) begin
        if (dio_oe || sdo_oe) n_early++;
      end else if (i < 26) begin
        if (dio_oe) n_dio++;
        if (sdo_oe) n_sdo++;
        rd[25-i] = expv[0][1] ? sdo_out : dio_out;
      end
      ser_clk = 1'b1;
      wclk(HALF);
      ser_clk = 1'b0;
    end
    wclk(HALF);
    ser_en_n = 1'b1;
    wclk(4*HALF);
  endtask

  task automatic do_write(input logic [1:0] dev, input logic [6:0] ra,
                          input logic [15:0] wd, input int nbits, input string req);
    logic [15:0] rd; int ne, nd, ns;
    bit sel;
    sel = m_sel(dev);
    frame(1'b0, dev, ra, wd, nbits, rd, ne, nd, ns);
    chk((ne + nd + ns) == 0 && !dio_oe && !sdo_oe, {req, " R6 write drives nothing"}, ne + nd + ns, 0);
    if (nbits == 26 && sel && ra < 7'd8) expv[ra[2:0]] = wd;
  endtask

  task automatic do_read(input logic [1:0] dev, input logic [6:0] ra, input string req);
    logic [15:0] rd; int ne, nd, ns;
    bit sel, fw;
    sel = m_sel(dev);
    fw = expv[0][1];
    frame(1'b1, dev, ra, 16'h0, 26, rd, ne, nd, ns);
    chk(ne == 0, {req, " R6 no drive during header"}, ne, 0);
    if (!sel) begin
      chk(nd == 0 && ns == 0, {req, " R8 unselected stays off"}, nd + ns, 0);
    end else if (fw) begin
      chk(ns == 16 && nd == 0, {req, " R7 four-wire enables"}, {nd[15:0], ns[15:0]}, 32'h10);
      chk(rd == m_read(ra), {req, " R5 R7 R10 read data"}, rd, m_read(ra));
    end else begin
      chk(nd == 16 && ns == 0, {req, " R6 three-wire enables"}, {nd[15:0], ns[15:0]}, 32'h100000);
      chk(rd == m_read(ra), {req, " R5 R10 read data"}, rd, m_read(ra));
    end
    chk(!dio_oe && !sdo_oe, {req, " R6 released after frame"}, {dio_oe, sdo_oe}, 0);
  endtask

  task automatic chk_core(input string req);
    logic ee, em;
    ee = expv[0][2] ? expv[0][3] : pin_enable;
    em = expv[0][2] ? expv[0][4] : pin_mode;
    wclk(1);
    chk(core_enable == ee && core_mode == em, {req, " R9 core outputs"},
        {core_enable, core_mode}, {ee, em});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'h5eed_0042);
    for (int i = 0; i < 8; i++) expv[i] = '0;
    wclk(5);
    rst_n = 1'b1;
    wclk(3);

    // R1: reset state
    chk(!dio_oe && !sdo_oe, "R1 enables low", {dio_oe, sdo_oe}, 0);
    pin_enable = 1'b1; pin_mode = 1'b0;
    chk_core("R1");
    do_read(2'b10, 7'd3, "R1 reset register");

    // R2: broadcast write with foreign device field
    do_write(2'b01, 7'd1, 16'hA5C3, 26, "R2");
    do_read(2'b00, 7'd1, "R2 broadcast readback");

    // R4: short and long frames dropped
    do_write(2'b10, 7'd2, 16'h1234, 25, "R4 short");
    do_read(2'b10, 7'd2, "R4 short dropped");
    do_write(2'b10, 7'd2, 16'h4321, 27, "R4 long");
    do_read(2'b10, 7'd2, "R4 long dropped");

    // R10: out-of-range index
    do_write(2'b10, 7'd100, 16'hFFFF, 26, "R10");
    do_read(2'b10, 7'd100, "R10 high index reads zero");

    // R3: enable addressing, foreign write ignored, own accepted
    do_write(2'b11, 7'd0, 16'h0001, 26, "R3 enable addressing");
    do_write(2'b01, 7'd1, 16'h0BAD, 26, "R3 foreign");
    do_read(2'b10, 7'd1, "R3 foreign ignored");
    do_read(2'b01, 7'd1, "R8 foreign read");
    do_write(2'b10, 7'd1, 16'h600D, 26, "R3 own");
    do_read(2'b10, 7'd1, "R3 own accepted");

    // R7: four-wire readback
    do_write(2'b10, 7'd0, 16'h0003, 26, "R7 four-wire on");
    do_read(2'b10, 7'd1, "R7 readback");
    do_read(2'b00, 7'd1, "R8 four-wire foreign");

    // R9: software override
    do_write(2'b10, 7'd0, 16'h0017, 26, "R9 override");
    pin_enable = 1'b0; pin_mode = 1'b1;
    chk_core("R9 override on");

    // random mix
    for (int it = 0; it < 40; it++) begin
      logic [1:0] dev; logic [6:0] ra; logic [15:0] wd; int nb;
      dev = 2'($urandom_range(0, 3));
      ra = 7'($urandom_range(0, 9));
      wd = 16'($urandom);
      if (ra == 7'd0) wd = wd & 16'h001F;
      nb = ($urandom_range(0, 7) == 0) ? 25 : 26;
      pin_enable = 1'($urandom); pin_mode = 1'($urandom);
      do_write(dev, ra, wd, nb, "R2 R3 R4 random write");
      do_read(2'($urandom_range(0, 3)), ra, "R5 random read");
      do_read(addr_strap, ra, "R5 random own read");
      chk_core("R9 random");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule